// File: doc/BRIEF.md
# DMA Channel Command and Status Slice

This block is the control register slice of one DMA channel. Software writes single-bit commands to a command register, and the slice runs a small lifecycle machine from them. The machine asks a transfer engine to start, to hold, or to abort. It also follows the engine's done and error reports and its halted acknowledge. It records what happened in a status word. That word holds two write-one-to-clear interrupt-pending bits and six lifecycle flags. An interrupt-enable register gates the pending bits onto one level interrupt line. An error-cause register collects the reason an error was reported.

The register bus is a plain word-indexed port: address, write data, a write strobe, and read data that follows the address without delay. The engine interface uses these signals. A one-cycle start pulse and a one-cycle abort pulse go out. A hold request stays high while the channel is holding or is asking to hold. Single-cycle done and error pulses come in, the error pulse with a three-bit cause. A halted level comes in from the engine.

Top module: `dma_chan_ctl`

## Requirements
- R1: After synchronous reset every register reads zero, and `irq`, `eng_start`, `eng_stop` and `eng_pause` are low. The registers are at word addresses 0 (command), 1 (status), 2 (interrupt enable) and 3 (error cause). Any other address reads zero.
- R2: The command register bits are enable=0, clear=1, disable=2, stop=3, pause=4 and resume=5. Each bit acts once, on the write cycle that carries it, and the command register always reads zero. Enable while idle moves the channel to running and gives a one-cycle `eng_start` pulse in the next cycle.
- R3: Enable has no effect while the channel is not idle. No start pulse is produced and no status bit changes.
- R4: Pause acts only while running. It raises `eng_pause`. Once `eng_halted` is seen high, status bit 20 (paused) is set. Pause given in any other state is ignored.
- R5: Resume acts only while paused. It drops `eng_pause` and sets status bit 21 (resume-wait) until `eng_halted` is seen low, and then the channel runs again. Resume given in any other state is ignored.
- R6: A done pulse from the engine while the channel is active (and not draining) returns it to idle and sets status bit 16 (done) and bit 0 (done pending).
- R7: An error pulse while the channel is active returns it to idle. It sets status bit 17 (error) and bit 1 (error pending), and ORs the cause into the error-cause register: bit 16 read response error, bit 17 write response error, bit 18 read poison.
- R8: Stop while active returns the channel to idle, gives a one-cycle `eng_stop` pulse and sets status bit 19 (stopped). Stop while idle has no effect.
- R9: Disable while running makes the channel drain. The next done pulse returns it to idle and sets status bit 18 (disabled) without setting done or done pending.
- R10: A write to status clears each pending bit (bits 0 and 1) whose write data bit is one, so writing back a value read from status clears what it showed. Such a write leaves bits 16 to 21 unchanged. A pending bit set by an event in the same cycle stays set.
- R11: The interrupt-enable register holds done-enable at bit 0 and error-enable at bit 1. `irq` is high exactly when some pending bit and its enable are both one.
- R12: Clear, in any state, returns the channel to idle and zeroes the status word and the error-cause register. It gives an `eng_stop` pulse if the channel was active. The interrupt-enable register keeps its value.
- R13: Priority within one cycle is clear, then stop, then an engine error, then an engine done, then disable, pause, resume and enable. A successful enable clears status bits 16 to 19 but keeps the pending bits and the error-cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| eng_start | output | 1 | One-cycle request to begin a transfer |
| eng_stop | output | 1 | One-cycle request to abort the transfer |
| eng_pause | output | 1 | Hold request level |
| eng_halted | input | 1 | Engine acknowledges it is holding |
| eng_done | input | 1 | Transfer finished pulse |
| eng_err | input | 1 | Transfer failed pulse |
| eng_err_code | input | ERR_W | Failure cause, valid with `eng_err` |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume the engine follows its handshake. `eng_halted` should rise only while `eng_pause` is high and fall only after it drops, and done or error pulses should last one cycle. Nothing is assumed about bus writes. Any command mix, including several bits in one write, is legal. The random stimulus drives `eng_halted` as a delayed copy of `eng_pause`. It sends done and error pulses sparsely and writes command words that are mostly one-hot, with clear kept rare so that long lifecycles occur. Directed phases place each command in the states where it must act and in states where it must be ignored.

// File: rtl/dma_chan_ctl_pkg.sv
package dma_chan_ctl_pkg;

    // register word indices
    localparam int REG_CMD     = 0;
    localparam int REG_STATUS  = 1;
    localparam int REG_INTEN   = 2;
    localparam int REG_ERRINFO = 3;

    // command bit positions
    localparam int CB_ENABLE  = 0;
    localparam int CB_CLEAR   = 1;
    localparam int CB_DISABLE = 2;
    localparam int CB_STOP    = 3;
    localparam int CB_PAUSE   = 4;
    localparam int CB_RESUME  = 5;
    localparam int CMD_BITS   = 6;

    // status bit positions
    localparam int SB_PEND_LO   = 0;
    localparam int SB_LIFE_LO   = 16;
    localparam int SB_PAUSED    = 20;
    localparam int SB_RESWAIT   = 21;
    localparam int PEND_BITS    = 2;
    localparam int LIFE_BITS    = 4;
    localparam int ERRINFO_LO   = 16;

    typedef enum logic [2:0] {
        CH_IDLE, CH_RUN, CH_PAUSING, CH_PAUSED, CH_RESUMING, CH_DRAIN
    } ch_state_e;

    typedef struct packed {
        logic en;
        logic clr;
        logic dis;
        logic stp;
        logic pse;
        logic rsm;
    } ch_cmd_t;

    // lifecycle events produced by the state machine for the status store
    typedef struct packed {
        logic wipe;
        logic launch;
        logic fin;
        logic fail;
        logic drained;
        logic aborted;
    } ch_evt_t;

    function automatic ch_cmd_t decode_cmd(input logic [CMD_BITS-1:0] b);
        ch_cmd_t c;
        c.en  = b[CB_ENABLE];
        c.clr = b[CB_CLEAR];
        c.dis = b[CB_DISABLE];
        c.stp = b[CB_STOP];
        c.pse = b[CB_PAUSE];
        c.rsm = b[CB_RESUME];
        return c;
    endfunction

endpackage

// File: rtl/dma_cc_cmd_dec.sv
module dma_cc_cmd_dec
    import dma_chan_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CMD_BITS-1:0] cmd_bits,
    output ch_cmd_t             cmd,
    output logic                stat_wr,
    output logic                inten_wr
);
    logic cmd_wr;

    assign cmd_wr   = bus_wr && (bus_addr == ADDR_W'(REG_CMD));
    assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(REG_STATUS));
    assign inten_wr = bus_wr && (bus_addr == ADDR_W'(REG_INTEN));
    assign cmd      = cmd_wr ? decode_cmd(cmd_bits) : '0;
endmodule

// File: rtl/dma_cc_fsm.sv
module dma_cc_fsm
    import dma_chan_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ch_cmd_t   cmd,
    input  logic      eng_done,
    input  logic      eng_err,
    input  logic      eng_halted,
    output ch_state_e state,
    output ch_evt_t   evt,
    output logic      eng_start,
    output logic      eng_stop,
    output logic      eng_pause
);
    ch_state_e st_q, st_d;
    logic      start_q, stop_q, start_d, stop_d, active;

    assign active = (st_q != CH_IDLE);

    always_comb begin
        st_d    = st_q;
        evt     = '0;
        start_d = 1'b0;
        stop_d  = 1'b0;
        if (cmd.clr) begin
            st_d     = CH_IDLE;
            evt.wipe = 1'b1;
            stop_d   = active;
        end else if (cmd.stp && active) begin
            st_d        = CH_IDLE;
            evt.aborted = 1'b1;
            stop_d      = 1'b1;
        end else if (eng_err && active) begin
            st_d     = CH_IDLE;
            evt.fail = 1'b1;
        end else if (eng_done && active) begin
            st_d = CH_IDLE;
            if (st_q == CH_DRAIN) evt.drained = 1'b1;
            else                  evt.fin     = 1'b1;
        end else if (cmd.dis && st_q == CH_RUN) begin
            st_d = CH_DRAIN;
        end else if (cmd.pse && st_q == CH_RUN) begin
            st_d = CH_PAUSING;
        end else if (cmd.rsm && st_q == CH_PAUSED) begin
            st_d = CH_RESUMING;
        end else if (cmd.en && st_q == CH_IDLE) begin
            st_d       = CH_RUN;
            evt.launch = 1'b1;
            start_d    = 1'b1;
        end else if (st_q == CH_PAUSING && eng_halted) begin
            st_d = CH_PAUSED;
        end else if (st_q == CH_RESUMING && !eng_halted) begin
            st_d = CH_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CH_IDLE;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= start_d;
            stop_q  <= stop_d;
        end
    end

    assign state     = st_q;
    assign eng_start = start_q;
    assign eng_stop  = stop_q;
    assign eng_pause = (st_q == CH_PAUSING) || (st_q == CH_PAUSED);
endmodule

// File: rtl/dma_cc_status.sv
module dma_cc_status
    import dma_chan_ctl_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ch_evt_t              evt,
    input  logic [ERR_W-1:0]     eng_err_code,
    input  logic                 stat_wr,
    input  logic                 inten_wr,
    input  logic [PEND_BITS-1:0] wdata_lo,
    output logic [PEND_BITS-1:0] pend,
    output logic [LIFE_BITS-1:0] life,
    output logic [ERR_W-1:0]     errinfo,
    output logic [PEND_BITS-1:0] inten,
    output logic                 irq
);
    // life: [0] done, [1] error, [2] disabled, [3] stopped
    // pend: [0] done pending, [1] error pending
    logic [PEND_BITS-1:0] pend_q, inten_q, w1c, pend_set;
    logic [LIFE_BITS-1:0] life_q, life_set;
    logic [ERR_W-1:0]     einfo_q;

    assign w1c      = stat_wr ? wdata_lo : '0;
    assign pend_set = {evt.fail, evt.fin};
    assign life_set = {evt.aborted, evt.drained, evt.fail, evt.fin};

    always_ff @(posedge clk) begin
        if (rst || evt.wipe) begin
            pend_q  <= '0;
            life_q  <= '0;
            einfo_q <= '0;
        end else begin
            pend_q <= (pend_q & ~w1c) | pend_set;
            if (evt.launch) life_q <= '0;
            else            life_q <= life_q | life_set;
            if (evt.fail)   einfo_q <= einfo_q | eng_err_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           inten_q <= '0;
        else if (inten_wr) inten_q <= wdata_lo;
    end

    assign pend    = pend_q;
    assign life    = life_q;
    assign errinfo = einfo_q;
    assign inten   = inten_q;
    assign irq     = |(pend_q & inten_q);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_start,
    output logic              eng_stop,
    output logic              eng_pause,
    input  logic              eng_halted,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [ERR_W-1:0]  eng_err_code,
    output logic              irq
);
    localparam int STAT_TOP = SB_RESWAIT + 1;
    localparam int EI_TOP   = ERRINFO_LO + ERR_W;

    ch_cmd_t              cmd;
    ch_evt_t              evt;
    ch_state_e            state;
    logic                 stat_wr, inten_wr;
    logic [PEND_BITS-1:0] pend, inten;
    logic [LIFE_BITS-1:0] life;
    logic [ERR_W-1:0]     errinfo;
    logic [DATA_W-1:0]    stat_word, err_word, inten_word;
    logic                 wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:CMD_BITS];

    dma_cc_cmd_dec #(.ADDR_W(ADDR_W)) dec_i (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cmd_bits (bus_wdata[CMD_BITS-1:0]),
        .cmd      (cmd),
        .stat_wr  (stat_wr),
        .inten_wr (inten_wr)
    );

    dma_cc_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .eng_halted (eng_halted),
        .state      (state),
        .evt        (evt),
        .eng_start  (eng_start),
        .eng_stop   (eng_stop),
        .eng_pause  (eng_pause)
    );

    dma_cc_status #(.ERR_W(ERR_W)) stat_i (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .eng_err_code (eng_err_code),
        .stat_wr      (stat_wr),
        .inten_wr     (inten_wr),
        .wdata_lo     (bus_wdata[PEND_BITS-1:0]),
        .pend         (pend),
        .life         (life),
        .errinfo      (errinfo),
        .inten        (inten),
        .irq          (irq)
    );

    always_comb begin
        stat_word = '0;
        stat_word[SB_PEND_LO +: PEND_BITS] = pend;
        stat_word[SB_LIFE_LO +: LIFE_BITS] = life;
        stat_word[SB_PAUSED]  = (state == CH_PAUSED);
        stat_word[SB_RESWAIT] = (state == CH_RESUMING);
        err_word = '0;
        err_word[ERRINFO_LO +: ERR_W] = errinfo;
        inten_word = '0;
        inten_word[PEND_BITS-1:0] = inten;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_STATUS):  bus_rdata = stat_word;
            ADDR_W'(REG_INTEN):   bus_rdata = inten_word;
            ADDR_W'(REG_ERRINFO): bus_rdata = err_word;
            default:              bus_rdata = '0;
        endcase
    end

    initial begin
        if (DATA_W < STAT_TOP || DATA_W < EI_TOP)
            $error("DATA_W too narrow for status or error-cause fields");
    end
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
    import dma_chan_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              eng_start,
    input logic              eng_pause,
    input logic              eng_done,
    input logic              irq,
    input logic [DATA_W-1:0] stat_word,
    input logic [DATA_W-1:0] err_word,
    input logic [1:0]        inten
);
    p_start_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    p_cmd_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(REG_CMD)) |-> (bus_rdata == '0));

    p_paused_after_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[SB_PAUSED]) |-> $past(eng_pause));

    p_reswait_from_paused_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[SB_RESWAIT]) |-> $past(stat_word[SB_PAUSED]));

    p_w1c_done_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(REG_STATUS) && bus_wdata[0] && !eng_done)
            |=> !stat_word[0]);

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
        (inten == 2'b00) |-> !irq);

    p_clear_wipes_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(REG_CMD) && bus_wdata[CB_CLEAR])
            |=> (stat_word == '0 && err_word == '0 && !irq));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_start (eng_start),
    .eng_pause (eng_pause),
    .eng_done  (eng_done),
    .irq       (irq),
    .stat_word (stat_word),
    .err_word  (err_word),
    .inten     (inten)
);

// File: tb/dma_chan_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start, eng_stop, eng_pause, irq;
    logic        eng_halted = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic [2:0]  eng_err_code = '0;

    always #2 clk = ~clk;

    dma_chan_ctl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_stop(eng_stop), .eng_pause(eng_pause), .eng_halted(eng_halted),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_code(eng_err_code),
        .irq(irq)
    );

    int    checks = 0, errors = 0;
    bit    finished = 0;
    string tag = "R1";
    logic  halted = 1'b0;

    // model: 0 idle 1 run 2 pausing 3 paused 4 resuming 5 drain
    int         m_st = 0;
    logic [1:0] m_pend = '0, m_inten = '0;
    logic [3:0] m_life = '0;
    logic [2:0] m_ei = '0;
    logic       m_start = 0, m_stop = 0;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            4'd1: begin
                v[1:0] = m_pend; v[19:16] = m_life;
                v[20] = (m_st == 3); v[21] = (m_st == 4);
            end
            4'd2: v[1:0] = m_inten;
            4'd3: v[18:16] = m_ei;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d,
                              input logic dn, input logic er, input logic [2:0] cd,
                              input logic hl);
        logic [5:0] c = (w && a == 4'd0) ? d[5:0] : 6'd0;
        logic       act = (m_st != 0);
        logic [1:0] pset = '0;
        logic [1:0] w1c = (w && a == 4'd1) ? d[1:0] : 2'b00;
        m_start = 0; m_stop = 0;
        if (c[1]) begin
            m_stop = act; m_st = 0; m_pend = '0; m_life = '0; m_ei = '0; w1c = '1;
        end else if (c[3] && act) begin
            m_stop = 1; m_st = 0; m_life[3] = 1;
        end else if (er && act) begin
            m_st = 0; m_life[1] = 1; pset[1] = 1; m_ei = m_ei | cd;
        end else if (dn && act) begin
            if (m_st == 5) m_life[2] = 1;
            else begin m_life[0] = 1; pset[0] = 1; end
            m_st = 0;
        end else if (c[2] && m_st == 1) m_st = 5;
        else if (c[4] && m_st == 1) m_st = 2;
        else if (c[5] && m_st == 3) m_st = 4;
        else if (c[0] && m_st == 0) begin m_st = 1; m_start = 1; m_life = '0; end
        else if (m_st == 2 && hl) m_st = 3;
        else if (m_st == 4 && !hl) m_st = 1;
        m_pend = (m_pend & ~w1c) | pset;
        if (w && a == 4'd2) m_inten = d[1:0];
    endtask

    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic dn = 0, input logic er = 0, input logic [2:0] cd = 0);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        eng_done = dn; eng_err = er; eng_err_code = cd; eng_halted = halted;
        #1;
        chk(bus_rdata, exp_read(a), tag);
        model_step(w, a, d, dn, er, cd, halted);
        @(posedge clk); #1;
        chk({31'b0, eng_start}, {31'b0, m_start}, {tag, " eng_start"});
        chk({31'b0, eng_stop},  {31'b0, m_stop},  {tag, " eng_stop"});
        chk({31'b0, eng_pause}, {31'b0, (m_st == 2 || m_st == 3)}, {tag, " eng_pause"});
        chk({31'b0, irq}, {31'b0, |(m_pend & m_inten)}, {tag, " irq"});
    endtask

    task automatic idle_reads();
        for (int a = 0; a < 5; a++) cyc(0, 4'(a), 0);
    endtask

    task automatic report();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        tag = "R1"; idle_reads();
        tag = "R11"; cyc(1, 2, 32'h3); idle_reads();
        tag = "R3"; cyc(1, 0, 32'h20); cyc(1, 0, 32'h10); idle_reads();      // resume/pause while idle
        tag = "R2"; cyc(1, 0, 32'h1); cyc(0, 0, 0); idle_reads();
        tag = "R3"; cyc(1, 0, 32'h1); idle_reads();                            // enable while running
        tag = "R5"; cyc(1, 0, 32'h20); idle_reads();                           // resume while running
        tag = "R4"; cyc(1, 0, 32'h10); cyc(0, 1, 0); halted = 1; cyc(0, 1, 0); cyc(0, 1, 0);
        cyc(1, 0, 32'h10); idle_reads();
        tag = "R5"; cyc(1, 0, 32'h20); cyc(0, 1, 0); halted = 0; cyc(0, 1, 0); cyc(0, 1, 0);
        tag = "R6"; cyc(0, 1, 0, 1); idle_reads();
        cyc(0, 1, 0, 1); idle_reads();                                         // done while idle
        tag = "R10"; cyc(1, 1, exp_read(1)); idle_reads();
        tag = "R7"; cyc(1, 0, 32'h1); cyc(0, 3, 0, 0, 1, 3'b101); idle_reads();
        tag = "R13"; cyc(1, 0, 32'h1); idle_reads();
        cyc(1, 0, 32'h9, 1); idle_reads();                                    // stop beats done
        tag = "R8"; cyc(1, 0, 32'h1); cyc(1, 0, 32'h8); idle_reads(); cyc(1, 0, 32'h8); idle_reads();
        tag = "R9"; cyc(1, 0, 32'h1); cyc(1, 0, 32'h4); cyc(0, 1, 0); cyc(0, 1, 0, 1); idle_reads();
        tag = "R12"; cyc(1, 0, 32'h1); cyc(0, 0, 0, 0, 1, 3'b010); cyc(1, 0, 32'h1);
        cyc(1, 0, 32'h2); idle_reads(); cyc(1, 0, 32'h2); idle_reads();

        tag = "mixed";
        for (int i = 0; i < 3000; i++) begin
            logic        w = ($urandom % 5) < 2;
            logic [3:0]  a = 4'($urandom % 5);
            logic [31:0] d = $urandom;
            if (a == 0) d = (($urandom % 12) == 0) ? 32'h2 : ((32'h1 << ($urandom % 6)) & ~32'h2);
            if (eng_pause && !halted && ($urandom % 3 == 0)) halted = 1;
            else if (!eng_pause && halted && ($urandom % 3 == 0)) halted = 0;
            cyc(w, a, d, ($urandom % 12) == 0, ($urandom % 14) == 0, 3'($urandom));
        end
        report();
    end
endmodule